// File: doc/BRIEF.md
# DMA Transfer Address Generator

This block produces the source and destination addresses of one DMA channel, one transfer unit at a time. A strobe copies two programmed start addresses into working registers and captures the channel's mode settings. After that, each advance strobe moves both working addresses by one unit. Each side moves according to its own direction setting: up, down, or not at all. The step is 1 for byte units and 2 for 16-bit units. Addresses are 24 bits wide and wrap around at both ends of the space.

The channel can run in two-bus-cycle mode or in one-bus-cycle mode. In two-bus-cycle mode the source and destination directions are independent, which gives nine combinations. In one-bus-cycle mode only one side is memory and the other is an external I/O port. The memory side follows its own direction field. The I/O side's address stays where it was loaded, and its direction field has no effect. A separate input pin, captured at load, says whether memory is the source (memory to I/O) or the destination (I/O to memory). Two flag outputs tell the bus sequencer which sides are memory.

All mode settings are sampled only at load. Changing the mode inputs or the start addresses during a transfer has no effect until the next load. The block has no data path and no stream: every pin is a plain control or status level, and a strobe acts in the cycle it is seen high.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset both address outputs are 0 and both memory flags are 1. Before the first load, advance strobes leave the addresses at 0 (both sides reset to fixed direction).
- R2: One cycle after `load_i` is high, `src_addr_o` and `dst_addr_o` equal the values `src_start_i` and `dst_start_i` had in the load cycle.
- R3: With direction code 00 (forward), each advance adds the step to that side's address. The step is 1 when mode bit 0 is 0 (byte unit) and 2 when mode bit 0 is 1 (16-bit unit).
- R4: With direction code 01 (backward), each advance subtracts the step from that side's address.
- R5: Direction code 10 (fixed) and the reserved code 11 both leave that side's address unchanged on an advance.
- R6: With mode bit 1 at 0 (two-bus-cycle), mode bits 5:4 set the source direction and mode bits 7:6 set the destination direction, independently; all nine combinations behave as in R3 to R5.
- R7: Address arithmetic wraps modulo 2^24, both when incrementing past 0xFFFFFF and when decrementing below 0.
- R8: With mode bit 1 at 1 (one-bus-cycle) and `io_to_mem_i` at 0 when loaded, the source is memory and follows bits 5:4. The destination address holds and bits 7:6 are ignored. `src_is_mem_o`=1 and `dst_is_mem_o`=0.
- R9: With mode bit 1 at 1 and `io_to_mem_i` at 1 when loaded, the destination is memory and follows bits 7:6. The source address holds and bits 5:4 are ignored. `src_is_mem_o`=0 and `dst_is_mem_o`=1.
- R10: Changes to `mode_i`, `io_to_mem_i` or the start inputs while `load_i` is low do not affect the addresses or flags until the next load.
- R11: When `load_i` and `adv_i` are high in the same cycle, the load wins: the next addresses are the start values, not stepped.
- R12: In a cycle with neither `load_i` nor `adv_i` high, both addresses hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Copy start addresses and capture mode settings |
| adv_i | input | 1 | Step working addresses by one transfer unit |
| mode_i | input | 8 | Bit 0 unit size (1 = 16-bit), bit 1 one-bus-cycle, bits 5:4 source direction, bits 7:6 destination direction, bits 3:2 unused |
| io_to_mem_i | input | 1 | One-bus-cycle transfer direction: 0 memory to I/O, 1 I/O to memory |
| src_start_i | input | 24 | Programmed source start address |
| dst_start_i | input | 24 | Programmed destination start address |
| src_addr_o | output | 24 | Current source address |
| dst_addr_o | output | 24 | Current destination address |
| src_is_mem_o | output | 1 | Source side is memory |
| dst_is_mem_o | output | 1 | Destination side is memory |

## Verification
Load and advance can land in the same cycle, because a channel restart can coincide with a unit completing. The bench provokes this by raising both strobes across one edge. It judges the result by requiring the start values, not stepped ones, and by checking that the following advance steps from those start values. A second overlap is a mode change during an advance. Here the bench changes `mode_i` and `io_to_mem_i` in the same cycle as an advance and expects the step and direction captured at the earlier load.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

  // Mode word layout; these positions are decoded by the mode latch.
  localparam int MODE_W     = 8;
  localparam int UNIT_BIT   = 0;
  localparam int ONEBUS_BIT = 1;
  localparam int SRC_LSB    = 4;
  localparam int DST_LSB    = 6;
  localparam int DIR_W      = 2;

  typedef enum logic [DIR_W-1:0] {
    DIR_FWD = 2'b00,
    DIR_BWD = 2'b01,
    DIR_FIX = 2'b10,
    DIR_RSV = 2'b11
  } dir_e;

  typedef struct packed {
    logic unit16;
    logic one_bus;
    logic io_to_mem;
    dir_e src_dir;
    dir_e dst_dir;
  } mode_cfg_t;

  localparam mode_cfg_t CFG_RESET = '{
    unit16:    1'b0,
    one_bus:   1'b0,
    io_to_mem: 1'b0,
    src_dir:   DIR_FIX,
    dst_dir:   DIR_FIX
  };

  function automatic mode_cfg_t decode_mode(input logic [MODE_W-1:0] m,
                                            input logic io_to_mem);
    mode_cfg_t c;
    c.unit16    = m[UNIT_BIT];
    c.one_bus   = m[ONEBUS_BIT];
    c.io_to_mem = io_to_mem;
    c.src_dir   = dir_e'(m[SRC_LSB +: DIR_W]);
    c.dst_dir   = dir_e'(m[DST_LSB +: DIR_W]);
    return c;
  endfunction

endpackage

// File: rtl/dma_mode_latch.sv
module dma_mode_latch
  import dma_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              io_to_mem_i,
  output mode_cfg_t         cfg_o,
  output dir_e              src_dir_o,
  output dir_e              dst_dir_o,
  output logic              src_mem_o,
  output logic              dst_mem_o
);

  mode_cfg_t cfg_q;
  mode_cfg_t cfg_d;
  logic      unused_mode_bits;

  // Bits between the bus-mode bit and the source field carry no meaning here.
  assign unused_mode_bits = ^mode_i[SRC_LSB-1:ONEBUS_BIT+1];

  always_comb begin
    cfg_d = cfg_q;
    if (load_i) cfg_d = decode_mode(mode_i, io_to_mem_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  // Effective per-side direction: in one-bus-cycle mode the I/O side is pinned.
  always_comb begin
    src_dir_o = cfg_q.src_dir;
    dst_dir_o = cfg_q.dst_dir;
    src_mem_o = 1'b1;
    dst_mem_o = 1'b1;
    if (cfg_q.one_bus) begin
      if (cfg_q.io_to_mem) begin
        src_dir_o = DIR_FIX;
        src_mem_o = 1'b0;
      end else begin
        dst_dir_o = DIR_FIX;
        dst_mem_o = 1'b0;
      end
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] start_i,
  input  dir_e              dir_i,
  input  logic              unit16_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  assign step = unit16_i ? STEP_WORD : STEP_BYTE;

  // Load has priority over advance; arithmetic wraps at the register width.
  always_comb begin
    addr_d = addr_q;
    if (load_i) begin
      addr_d = start_i;
    end else if (adv_i) begin
      case (dir_i)
        DIR_FWD: addr_d = addr_q + step;
        DIR_BWD: addr_d = addr_q - step;
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              io_to_mem_i,
  input  logic [ADDR_W-1:0] src_start_i,
  input  logic [ADDR_W-1:0] dst_start_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              src_is_mem_o,
  output logic              dst_is_mem_o
);

  localparam int N_SIDES = 2;
  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;

  mode_cfg_t         cfg_q;
  dir_e              eff_src_dir;
  dir_e              eff_dst_dir;
  logic [ADDR_W-1:0] start_a [N_SIDES];
  logic [ADDR_W-1:0] addr_a  [N_SIDES];
  dir_e              dir_a   [N_SIDES];

  dma_mode_latch u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .mode_i      (mode_i),
    .io_to_mem_i (io_to_mem_i),
    .cfg_o       (cfg_q),
    .src_dir_o   (eff_src_dir),
    .dst_dir_o   (eff_dst_dir),
    .src_mem_o   (src_is_mem_o),
    .dst_mem_o   (dst_is_mem_o)
  );

  assign start_a[SIDE_SRC] = src_start_i;
  assign start_a[SIDE_DST] = dst_start_i;
  assign dir_a[SIDE_SRC]   = eff_src_dir;
  assign dir_a[SIDE_DST]   = eff_dst_dir;

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .adv_i    (adv_i),
      .start_i  (start_a[s]),
      .dir_i    (dir_a[s]),
      .unit16_i (cfg_q.unit16),
      .addr_o   (addr_a[s])
    );
  end

  assign src_addr_o = addr_a[SIDE_SRC];
  assign dst_addr_o = addr_a[SIDE_DST];

endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] src_start_i,
  input logic [ADDR_W-1:0] dst_start_i,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic [ADDR_W-1:0] dst_addr_o,
  input logic              src_is_mem_o,
  input logic              dst_is_mem_o,
  input mode_cfg_t         cfg_q,
  input dir_e              eff_src_dir,
  input dir_e              eff_dst_dir
);

  logic [ADDR_W-1:0] chk_step;
  assign chk_step = cfg_q.unit16 ? ADDR_W'(2) : ADDR_W'(1);

  // R2 and R11: a load always yields the start values next cycle.
  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (src_addr_o == $past(src_start_i)) && (dst_addr_o == $past(dst_start_i)));

  // R3
  a_r3_src_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && eff_src_dir == DIR_FWD) |=>
      src_addr_o == $past(src_addr_o) + $past(chk_step));

  // R4
  a_r4_dst_backward: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && eff_dst_dir == DIR_BWD) |=>
      dst_addr_o == $past(dst_addr_o) - $past(chk_step));

  // R5
  a_r5_src_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (eff_src_dir == DIR_FIX || eff_src_dir == DIR_RSV)) |=> $stable(src_addr_o));

  // R8
  a_r8_mem_to_io_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.one_bus && !cfg_q.io_to_mem) |-> (src_is_mem_o && !dst_is_mem_o));

  a_r8_io_dst_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.one_bus && !cfg_q.io_to_mem && !load_i) |=> $stable(dst_addr_o));

  // R9
  a_r9_io_src_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.one_bus && cfg_q.io_to_mem && !load_i) |=> $stable(src_addr_o));

  a_r9_one_mem_side: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.one_bus |-> $countones({src_is_mem_o, dst_is_mem_o}) == 1);

  // R10
  a_r10_cfg_only_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(cfg_q));

  // R12
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> ($stable(src_addr_o) && $stable(dst_addr_o)));

endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .adv_i        (adv_i),
  .src_start_i  (src_start_i),
  .dst_start_i  (dst_start_i),
  .src_addr_o   (src_addr_o),
  .dst_addr_o   (dst_addr_o),
  .src_is_mem_o (src_is_mem_o),
  .dst_is_mem_o (dst_is_mem_o),
  .cfg_q        (cfg_q),
  .eff_src_dir  (eff_src_dir),
  .eff_dst_dir  (eff_dst_dir)
);

// File: tb/tb_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_addr_gen;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_i = 1'b0;
  logic [7:0]    mode_i = '0;
  logic          io_to_mem_i = 1'b0;
  logic [AW-1:0] src_start_i = '0;
  logic [AW-1:0] dst_start_i = '0;
  logic [AW-1:0] src_addr_o;
  logic [AW-1:0] dst_addr_o;
  logic          src_is_mem_o;
  logic          dst_is_mem_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .mode_i(mode_i), .io_to_mem_i(io_to_mem_i),
    .src_start_i(src_start_i), .dst_start_i(dst_start_i),
    .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
    .src_is_mem_o(src_is_mem_o), .dst_is_mem_o(dst_is_mem_o)
  );

  // Mode word: bit0 unit16, bit1 one-bus, [5:4] source dir, [7:6] dest dir.
  function automatic logic [7:0] mk_mode(input logic u16, input logic ob,
                                         input logic [1:0] sd, input logic [1:0] dd);
    return {dd, sd, 2'b00, ob, u16};
  endfunction

  // Expected address after one advance, from R3/R4/R5/R7.
  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input logic [1:0] d,
                                            input logic u16);
    logic [AW-1:0] st;
    st = u16 ? AW'(2) : AW'(1);
    if (d == 2'b00) return a + st;
    if (d == 2'b01) return a - st;
    return a;
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] m, input logic i2m,
                         input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    mode_i = m; io_to_mem_i = i2m; src_start_i = s; dst_start_i = d; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      adv_i = 1'b1;
    end
    @(negedge clk);
    adv_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 src after reset", src_addr_o, '0);
    check("R1 dst after reset", dst_addr_o, '0);
    check("R1 src_is_mem after reset", AW'(src_is_mem_o), AW'(1));
    check("R1 dst_is_mem after reset", AW'(dst_is_mem_o), AW'(1));
    do_adv(2);
    check("R1 src still 0 before load", src_addr_o, '0);
    check("R1 dst still 0 before load", dst_addr_o, '0);
  endtask

  task automatic t_fwd_byte;
    do_load(mk_mode(1'b0, 1'b0, 2'b00, 2'b00), 1'b0, 24'h000100, 24'h000200);
    check("R2 src loaded", src_addr_o, 24'h000100);
    check("R2 dst loaded", dst_addr_o, 24'h000200);
    do_adv(3);
    check("R3 src fwd byte x3", src_addr_o, 24'h000103);
    check("R3 dst fwd byte x3", dst_addr_o, 24'h000203);
  endtask

  task automatic t_bwd_word;
    do_load(mk_mode(1'b1, 1'b0, 2'b01, 2'b01), 1'b0, 24'h001000, 24'h00A000);
    do_adv(2);
    check("R4 src bwd word x2", src_addr_o, 24'h000FFC);
    check("R4 dst bwd word x2", dst_addr_o, 24'h009FFC);
  endtask

  task automatic t_fixed;
    do_load(mk_mode(1'b1, 1'b0, 2'b10, 2'b11), 1'b0, 24'h123456, 24'h654321);
    do_adv(4);
    check("R5 src fixed code 10", src_addr_o, 24'h123456);
    check("R5 dst reserved code 11", dst_addr_o, 24'h654321);
  endtask

  task automatic t_nine;
    for (int si = 0; si < 3; si++) begin
      for (int di = 0; di < 3; di++) begin
        do_load(mk_mode(1'b1, 1'b0, 2'(si), 2'(di)), 1'b0, 24'h800000, 24'h400000);
        do_adv(1);
        check($sformatf("R6 src combo s%0d d%0d", si, di), src_addr_o,
              stepped(24'h800000, 2'(si), 1'b1));
        check($sformatf("R6 dst combo s%0d d%0d", si, di), dst_addr_o,
              stepped(24'h400000, 2'(di), 1'b1));
      end
    end
  endtask

  task automatic t_wrap;
    do_load(mk_mode(1'b1, 1'b0, 2'b00, 2'b01), 1'b0, 24'hFFFFFF, 24'h000000);
    do_adv(1);
    check("R7 src wraps up", src_addr_o, 24'h000001);
    check("R7 dst wraps down", dst_addr_o, 24'hFFFFFE);
    do_load(mk_mode(1'b0, 1'b0, 2'b01, 2'b00), 1'b0, 24'h000000, 24'hFFFFFF);
    do_adv(1);
    check("R7 src byte wraps down", src_addr_o, 24'hFFFFFF);
    check("R7 dst byte wraps up", dst_addr_o, 24'h000000);
  endtask

  task automatic t_mem_to_io;
    do_load(mk_mode(1'b0, 1'b1, 2'b01, 2'b00), 1'b0, 24'h000050, 24'h00F000);
    check("R8 src_is_mem", AW'(src_is_mem_o), AW'(1));
    check("R8 dst_is_mem", AW'(dst_is_mem_o), AW'(0));
    do_adv(3);
    check("R8 src follows bits 5:4", src_addr_o, 24'h00004D);
    check("R8 dst held, bits 7:6 ignored", dst_addr_o, 24'h00F000);
  endtask

  task automatic t_io_to_mem;
    do_load(mk_mode(1'b1, 1'b1, 2'b00, 2'b00), 1'b1, 24'h00E000, 24'h000300);
    check("R9 src_is_mem", AW'(src_is_mem_o), AW'(0));
    check("R9 dst_is_mem", AW'(dst_is_mem_o), AW'(1));
    do_adv(2);
    check("R9 dst follows bits 7:6", dst_addr_o, 24'h000304);
    check("R9 src held, bits 5:4 ignored", src_addr_o, 24'h00E000);
  endtask

  task automatic t_sample;
    do_load(mk_mode(1'b0, 1'b0, 2'b00, 2'b00), 1'b0, 24'h000010, 24'h000020);
    @(negedge clk);
    mode_i = mk_mode(1'b1, 1'b1, 2'b01, 2'b01);
    io_to_mem_i = 1'b1;
    src_start_i = 24'hAAAAAA;
    dst_start_i = 24'h555555;
    adv_i = 1'b1;
    @(negedge clk);
    adv_i = 1'b0;
    check("R10 src uses captured mode", src_addr_o, 24'h000011);
    check("R10 dst uses captured mode", dst_addr_o, 24'h000021);
    check("R10 src_is_mem unchanged", AW'(src_is_mem_o), AW'(1));
    check("R10 dst_is_mem unchanged", AW'(dst_is_mem_o), AW'(1));
  endtask

  task automatic t_collide;
    @(negedge clk);
    mode_i = mk_mode(1'b1, 1'b0, 2'b00, 2'b01);
    io_to_mem_i = 1'b0;
    src_start_i = 24'h000400;
    dst_start_i = 24'h000800;
    load_i = 1'b1;
    adv_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    adv_i = 1'b0;
    check("R11 src load wins over advance", src_addr_o, 24'h000400);
    check("R11 dst load wins over advance", dst_addr_o, 24'h000800);
    do_adv(1);
    check("R11 src steps from start", src_addr_o, 24'h000402);
    check("R11 dst steps from start", dst_addr_o, 24'h0007FE);
  endtask

  task automatic t_idle;
    do_load(mk_mode(1'b1, 1'b0, 2'b00, 2'b01), 1'b0, 24'h000A00, 24'h000B00);
    repeat (5) @(negedge clk);
    check("R12 src idle holds", src_addr_o, 24'h000A00);
    check("R12 dst idle holds", dst_addr_o, 24'h000B00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fwd_byte();
    t_bwd_word();
    t_fixed();
    t_nine();
    t_wrap();
    t_mem_to_io();
    t_io_to_mem();
    t_sample();
    t_collide();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (run incomplete) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule